// File: doc/BRIEF.md
# Read-Leveling Delay Sweep Sequencer

This block runs the read data-eye calibration of a DDR PHY with several byte lanes. After a host start it puts the PHY leveling engine into read data-eye mode and sends it a begin request. It then walks each lane's strobe-to-data delay code over the whole code range. At every code it writes the delay, sends a load request, waits for the engine to acknowledge, and records whether the lane's response means pass. Each request goes out as a one-cycle pulse and is followed by a wait for the engine's done input.

When a lane's sweep ends, a serial edge scanner searches the lane's pass map for the first clean rising edge and, after it, the first clean falling edge. The lane result is half the distance between the two. If either edge is missing, or the half-distance is zero, the lane falls back to a default captured at start. After the last lane, the block writes all results to the PHY and loads them. It then sends an exit request and, once that is acknowledged, drops busy and gives the host a one-cycle done pulse. The results stay readable until the next run.

Top module: `rdlvl_sweep_seq`

## Requirements
- R1: After reset, `cal_busy_o`, `cal_done_o`, every request pulse, `lvl_mode_o`, `lane_dly_o` and `phy_dly_o` are all zero.
- R2: `cal_start_i` is accepted only when the block is idle; a start while busy has no effect on the request sequence. For every busy cycle `lvl_mode_o` is 2'b10 (read data-eye), it is 2'b00 when idle, and `lvl_edge_o` stays 0.
- R3: The first request of a run is one begin pulse on `lvl_start_o`. No further request is sent until `lvl_done_i` has been seen high after it, and the same holds after every later request.
- R4: Lane 0 is swept fully before lane 1. Each lane takes codes 0 to 255 in ascending order, with one load pulse per code, and the code is already on that lane's slice of `phy_dly_o` when its load pulse is sent. During the lane-0 sweep, lane 1 carries its default. During the lane-1 sweep, lane 0 keeps code 255.
- R5: A lane passes at a code only when its 4-bit response, sampled in the cycle `lvl_done_i` acknowledges that code's load, equals exactly 4'b0000. Any other value is a fail. The pass map is cleared before each lane's sweep.
- R6: The rising edge is the lowest index i with 4 <= i <= 251 such that bit i-1 of the pass map is clear and bits i to i+3 are set.
- R7: The falling edge is the lowest index i with rising index <= i <= 251 such that bit i is clear and bits i-1, i-2 and i-3 are set.
- R8: The lane result is (falling index - rising index) / 2, truncated toward zero.
- R9: A lane takes its default if either edge is missing or the computed result is zero. The default is the lane's slice of `dflt_dly_i` as sampled when start was accepted.
- R10: After the last lane, all lane slices of `phy_dly_o` carry the results, then come one load pulse, a done wait, one exit pulse and a done wait. Next, `cal_done_o` pulses for one cycle, in the same cycle that `cal_busy_o` falls. `lane_dly_o` holds the results while idle.
- R11: Request pulses are each exactly one cycle wide, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_start_i | input | 1 | Host request to run calibration |
| dflt_dly_i | input | NUM_LANES*DLY_W | Per-lane fallback delays, lane 0 in the low slice |
| cal_busy_o | output | 1 | Calibration in progress |
| cal_done_o | output | 1 | One-cycle completion pulse |
| lane_dly_o | output | NUM_LANES*DLY_W | Per-lane calibration results |
| lvl_mode_o | output | 2 | Leveling mode to the PHY engine |
| lvl_edge_o | output | 1 | Strobe-edge select, held 0 |
| lvl_start_o | output | 1 | Begin-leveling request pulse |
| lvl_load_o | output | 1 | Load-delay request pulse |
| lvl_exit_o | output | 1 | Exit-leveling request pulse |
| lvl_done_i | input | 1 | Engine acknowledge for the last request |
| phy_dly_o | output | NUM_LANES*DLY_W | Per-lane delay codes driven to the PHY |
| lvl_rsp_i | input | NUM_LANES*RSP_W | Per-lane leveling responses |

## Verification
On every cycle the assertions check the request rules: single-cycle pulses that never overlap, no request while an earlier one is still waiting for acknowledge, requests only while busy, the mode tied to busy, done coinciding with the fall of busy, and results held stable while idle. Whether the codes step in the right order and reach the PHY before each load, and whether the edge search and halving give the right value, can only be shown by the bench's scenarios. Those scenarios use chosen pass windows: narrow and odd-width windows, glitches, windows touching either end of the range, empty lanes and a second window. Their results are compared with an independently computed expectation, and a reference queue of expected requests is checked on every clock.

// File: rtl/rdlvl_pkg.sv
package rdlvl_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_BEGIN,
    S_BEGIN_WT,
    S_STEP,
    S_LOAD,
    S_LOAD_WT,
    S_SCAN,
    S_SCAN_WT,
    S_FINAL,
    S_FINAL_LD,
    S_FINAL_WT,
    S_EXIT,
    S_EXIT_WT
  } seq_state_e;

  localparam logic [1:0] LVL_MODE_OFF    = 2'b00;
  localparam logic [1:0] LVL_MODE_RD_EYE = 2'b10;

endpackage

// File: rtl/rdlvl_pass_map.sv
module rdlvl_pass_map #(
  parameter int DLY_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  set_i,
  input  logic [DLY_W-1:0]      idx_i,
  output logic [(1<<DLY_W)-1:0] map_o
);

  localparam int MAP_D = 1 << DLY_W;

  logic [MAP_D-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q <= '0;
    end else if (clr_i) begin
      map_q <= '0;
    end else if (set_i) begin
      map_q[idx_i] <= 1'b1;
    end
  end

  assign map_o = map_q;

endmodule

// File: rtl/rdlvl_edge_scan.sv
// Walks the pass map one index per cycle: rising edge first, then falling edge.
module rdlvl_edge_scan #(
  parameter int DLY_W = 8,
  parameter int RUN   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  go_i,
  input  logic [(1<<DLY_W)-1:0] map_i,
  output logic                  done_o,
  output logic                  rise_ok_o,
  output logic [DLY_W-1:0]      rise_idx_o,
  output logic                  fall_ok_o,
  output logic [DLY_W-1:0]      fall_idx_o
);

  localparam int              MAP_D     = 1 << DLY_W;
  localparam logic [DLY_W-1:0] IDX_FIRST = DLY_W'(RUN);
  localparam logic [DLY_W-1:0] IDX_LAST  = DLY_W'(MAP_D - 1 - RUN);

  logic             run_q, fall_ph_q, done_q;
  logic             rise_ok_q, fall_ok_q;
  logic [DLY_W-1:0] idx_q, rise_idx_q, fall_idx_q;
  logic             rise_hit, fall_hit;

  always_comb begin
    rise_hit = map_i[idx_q] & ~map_i[idx_q - 1'b1];
    fall_hit = ~map_i[idx_q];
    for (int k = 1; k < RUN; k++) begin
      rise_hit = rise_hit & map_i[idx_q + DLY_W'(k)];
    end
    for (int k = 1; k < RUN; k++) begin
      fall_hit = fall_hit & map_i[idx_q - DLY_W'(k)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      fall_ph_q  <= 1'b0;
      done_q     <= 1'b0;
      rise_ok_q  <= 1'b0;
      fall_ok_q  <= 1'b0;
      idx_q      <= '0;
      rise_idx_q <= '0;
      fall_idx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        run_q     <= 1'b1;
        fall_ph_q <= 1'b0;
        rise_ok_q <= 1'b0;
        fall_ok_q <= 1'b0;
        idx_q     <= IDX_FIRST;
      end else if (run_q) begin
        if (!fall_ph_q && rise_hit) begin
          rise_ok_q  <= 1'b1;
          rise_idx_q <= idx_q;
          fall_ph_q  <= 1'b1;
        end
        if (fall_ph_q && fall_hit) begin
          fall_ok_q  <= 1'b1;
          fall_idx_q <= idx_q;
          run_q      <= 1'b0;
          done_q     <= 1'b1;
        end else if (idx_q == IDX_LAST) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign done_o     = done_q;
  assign rise_ok_o  = rise_ok_q;
  assign rise_idx_o = rise_idx_q;
  assign fall_ok_o  = fall_ok_q;
  assign fall_idx_o = fall_idx_q;

endmodule

// File: rtl/rdlvl_sweep_seq.sv
module rdlvl_sweep_seq
  import rdlvl_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int DLY_W     = 8,
  parameter int RSP_W     = 4,
  parameter int EDGE_RUN  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cal_start_i,
  input  logic [NUM_LANES*DLY_W-1:0] dflt_dly_i,
  output logic                       cal_busy_o,
  output logic                       cal_done_o,
  output logic [NUM_LANES*DLY_W-1:0] lane_dly_o,
  output logic [1:0]                 lvl_mode_o,
  output logic                       lvl_edge_o,
  output logic                       lvl_start_o,
  output logic                       lvl_load_o,
  output logic                       lvl_exit_o,
  input  logic                       lvl_done_i,
  output logic [NUM_LANES*DLY_W-1:0] phy_dly_o,
  input  logic [NUM_LANES*RSP_W-1:0] lvl_rsp_i
);

  localparam int               LANE_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int               MAP_D     = 1 << DLY_W;
  localparam logic [DLY_W-1:0]  CODE_MAX  = '1;
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(NUM_LANES - 1);

  seq_state_e state_q, state_d;

  logic [LANE_W-1:0] lane_q;
  logic [DLY_W-1:0]  code_q;
  logic [DLY_W-1:0]  dly_q  [NUM_LANES];
  logic [DLY_W-1:0]  dflt_q [NUM_LANES];
  logic [DLY_W-1:0]  res_q  [NUM_LANES];
  logic [DLY_W-1:0]  dflt_w [NUM_LANES];
  logic              done_q;

  logic [RSP_W-1:0]  rsp_sel;
  logic              map_clr, map_set, scan_go;
  logic [MAP_D-1:0]  pass_map;
  logic              scan_done, rise_ok, fall_ok;
  logic [DLY_W-1:0]  rise_idx, fall_idx;
  logic [DLY_W-1:0]  span, half, lane_final;
  logic              take_dflt, last_lane;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign dflt_w[g]                     = dflt_dly_i[g*DLY_W +: DLY_W];
    assign phy_dly_o[g*DLY_W +: DLY_W]  = dly_q[g];
    assign lane_dly_o[g*DLY_W +: DLY_W] = res_q[g];
  end

  assign rsp_sel   = lvl_rsp_i[lane_q*RSP_W +: RSP_W];
  assign last_lane = (lane_q == LANE_LAST);

  // Map bookkeeping
  assign map_set = (state_q == S_LOAD_WT) && lvl_done_i && (rsp_sel == '0);
  assign map_clr = ((state_q == S_BEGIN_WT) && lvl_done_i) ||
                   ((state_q == S_SCAN_WT) && scan_done && !last_lane);
  assign scan_go = (state_q == S_SCAN);

  rdlvl_pass_map #(.DLY_W(DLY_W)) u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (map_clr),
    .set_i  (map_set),
    .idx_i  (code_q),
    .map_o  (pass_map)
  );

  rdlvl_edge_scan #(.DLY_W(DLY_W), .RUN(EDGE_RUN)) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (scan_go),
    .map_i      (pass_map),
    .done_o     (scan_done),
    .rise_ok_o  (rise_ok),
    .rise_idx_o (rise_idx),
    .fall_ok_o  (fall_ok),
    .fall_idx_o (fall_idx)
  );

  // Half window width, or the captured default
  always_comb begin
    span       = fall_idx - rise_idx;
    half       = span >> 1;
    take_dflt  = !rise_ok || !fall_ok || (half == '0);
    lane_final = take_dflt ? dflt_q[lane_q] : half;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (cal_start_i) state_d = S_BEGIN;
      S_BEGIN:    state_d = S_BEGIN_WT;
      S_BEGIN_WT: if (lvl_done_i) state_d = S_STEP;
      S_STEP:     state_d = S_LOAD;
      S_LOAD:     state_d = S_LOAD_WT;
      S_LOAD_WT:  if (lvl_done_i) state_d = (code_q == CODE_MAX) ? S_SCAN : S_STEP;
      S_SCAN:     state_d = S_SCAN_WT;
      S_SCAN_WT:  if (scan_done) state_d = last_lane ? S_FINAL : S_STEP;
      S_FINAL:    state_d = S_FINAL_LD;
      S_FINAL_LD: state_d = S_FINAL_WT;
      S_FINAL_WT: if (lvl_done_i) state_d = S_EXIT;
      S_EXIT:     state_d = S_EXIT_WT;
      S_EXIT_WT:  if (lvl_done_i) state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      lane_q  <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
      for (int l = 0; l < NUM_LANES; l++) begin
        dly_q[l]  <= '0;
        dflt_q[l] <= '0;
        res_q[l]  <= '0;
      end
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (cal_start_i) begin
          lane_q <= '0;
          code_q <= '0;
          for (int l = 0; l < NUM_LANES; l++) begin
            dflt_q[l] <= dflt_w[l];
            dly_q[l]  <= dflt_w[l];
          end
        end
        S_STEP:    dly_q[lane_q] <= code_q;
        S_LOAD_WT: if (lvl_done_i && code_q != CODE_MAX) code_q <= code_q + 1'b1;
        S_SCAN_WT: if (scan_done) begin
          res_q[lane_q] <= lane_final;
          if (!last_lane) begin
            lane_q <= lane_q + 1'b1;
            code_q <= '0;
          end
        end
        S_FINAL: begin
          for (int l = 0; l < NUM_LANES; l++) dly_q[l] <= res_q[l];
        end
        S_EXIT_WT: if (lvl_done_i) done_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign cal_busy_o  = (state_q != S_IDLE);
  assign cal_done_o  = done_q;
  assign lvl_mode_o  = cal_busy_o ? LVL_MODE_RD_EYE : LVL_MODE_OFF;
  assign lvl_edge_o  = 1'b0;
  assign lvl_start_o = (state_q == S_BEGIN);
  assign lvl_load_o  = (state_q == S_LOAD) || (state_q == S_FINAL_LD);
  assign lvl_exit_o  = (state_q == S_EXIT);

endmodule

// File: rtl/rdlvl_sweep_seq_chk.sv
module rdlvl_sweep_seq_chk #(
  parameter int NUM_LANES = 2,
  parameter int DLY_W     = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       cal_busy_o,
  input logic                       cal_done_o,
  input logic [NUM_LANES*DLY_W-1:0] lane_dly_o,
  input logic [1:0]                 lvl_mode_o,
  input logic                       lvl_start_o,
  input logic                       lvl_load_o,
  input logic                       lvl_exit_o,
  input logic                       lvl_done_i
);

  logic any_req, pend_q;
  assign any_req = lvl_start_o | lvl_load_o | lvl_exit_o;

  // Request issued and not yet acknowledged
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (any_req)    pend_q <= 1'b1;
    else if (lvl_done_i) pend_q <= 1'b0;
  end

  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |-> !pend_q);

  p_pulse_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lvl_start_o, lvl_load_o, lvl_exit_o}));

  p_start_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_start_o |=> !lvl_start_o);

  p_load_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_load_o |=> !lvl_load_o);

  p_exit_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_exit_o |=> !lvl_exit_o);

  p_req_in_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |-> cal_busy_o);

  p_mode_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_busy_o |-> (lvl_mode_o == 2'b10));

  p_mode_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_busy_o |-> (lvl_mode_o == 2'b00));

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |-> !cal_busy_o);

  p_busy_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cal_busy_o) |-> cal_done_o);

  p_result_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_busy_o |=> $stable(lane_dly_o));

endmodule

bind rdlvl_sweep_seq rdlvl_sweep_seq_chk #(
  .NUM_LANES (NUM_LANES),
  .DLY_W     (DLY_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cal_busy_o  (cal_busy_o),
  .cal_done_o  (cal_done_o),
  .lane_dly_o  (lane_dly_o),
  .lvl_mode_o  (lvl_mode_o),
  .lvl_start_o (lvl_start_o),
  .lvl_load_o  (lvl_load_o),
  .lvl_exit_o  (lvl_exit_o),
  .lvl_done_i  (lvl_done_i)
);

// File: tb/sim_rdlvl_sweep_seq.sv
module sim_rdlvl_sweep_seq;

  localparam int CLK_PERIOD = 10;
  localparam int MAXC       = 255;
  localparam int RUN        = 4;
  localparam int ACK_LAT    = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_start = 1'b0;
  logic [15:0] dflt_dly = '0;
  logic        busy, done_o, edge_sel, lvl_start, lvl_load, lvl_exit;
  logic        lvl_done = 1'b0;
  logic [15:0] lane_dly, phy_dly;
  logic [1:0]  mode;
  logic [7:0]  lvl_rsp;

  int n_tests = 0;
  int n_fail  = 0;

  int lo1[2], hi1[2], lo2[2], hi2[2];

  int          q_kind[$];
  logic [15:0] q_dly[$];
  string       q_tag[$];
  bit          chk_busy = 0;
  bit          done_seen = 0;
  int          ack_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdlvl_sweep_seq u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cal_start_i (cal_start),
    .dflt_dly_i  (dflt_dly),
    .cal_busy_o  (busy),
    .cal_done_o  (done_o),
    .lane_dly_o  (lane_dly),
    .lvl_mode_o  (mode),
    .lvl_edge_o  (edge_sel),
    .lvl_start_o (lvl_start),
    .lvl_load_o  (lvl_load),
    .lvl_exit_o  (lvl_exit),
    .lvl_done_i  (lvl_done),
    .phy_dly_o   (phy_dly),
    .lvl_rsp_i   (lvl_rsp)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit stub_pass(int l, int c);
    return (c >= lo1[l] && c <= hi1[l]) || (c >= lo2[l] && c <= hi2[l]);
  endfunction

  // PHY stub: responses from the programmed windows, acknowledge after ACK_LAT
  always_comb begin
    for (int l = 0; l < 2; l++) begin
      if (stub_pass(l, int'(phy_dly[l*8 +: 8]))) lvl_rsp[l*4 +: 4] = 4'h0;
      else lvl_rsp[l*4 +: 4] = 4'(1 << phy_dly[l*8 +: 2]);
    end
  end

  always @(posedge clk) begin
    if (lvl_start | lvl_load | lvl_exit) ack_cnt <= ACK_LAT;
    else if (ack_cnt != 0) ack_cnt <= ack_cnt - 1;
    lvl_done <= (ack_cnt == 1);
  end

  // Reference model: expected result per requirements R6 to R9
  function automatic int ref_result(int l, int dflt);
    bit p[MAXC+1];
    int rise, fall, res;
    for (int c = 0; c <= MAXC; c++) p[c] = stub_pass(l, c);
    rise = -1;
    fall = -1;
    for (int i = RUN; i <= MAXC - RUN; i++) begin
      if (p[i] && !p[i-1] && p[i+1] && p[i+2] && p[i+3]) begin
        rise = i;
        break;
      end
    end
    if (rise >= 0) begin
      for (int i = rise; i <= MAXC - RUN; i++) begin
        if (!p[i] && p[i-1] && p[i-2] && p[i-3]) begin
          fall = i;
          break;
        end
      end
    end
    res = (fall - rise) / 2;
    if (rise < 0 || fall < 0 || res <= 0) res = dflt;
    return res;
  endfunction

  // Per-clock comparison against the expected request queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (lvl_start | lvl_load | lvl_exit) begin
        int k;
        k = lvl_start ? 0 : (lvl_load ? 1 : 2);
        if (q_kind.size() == 0) begin
          chk(1'b0, "R3 unexpected request", k, -1);
        end else begin
          int ek;
          logic [15:0] ed;
          string et;
          ek = q_kind.pop_front();
          ed = q_dly.pop_front();
          et = q_tag.pop_front();
          chk(k == ek, et, k, ek);
          if (ek == 1) chk(phy_dly == ed, et, phy_dly, ed);
        end
      end
      if (chk_busy && q_kind.size() != 0) chk(busy == 1'b1, "R2 busy", busy, 1);
      chk(mode == (busy ? 2'b10 : 2'b00), "R2 mode", mode, busy ? 2 : 0);
      chk(edge_sel == 1'b0, "R2 edge", edge_sel, 0);
      if (done_o) begin
        chk(q_kind.size() == 0, "R10 done early", q_kind.size(), 0);
        chk(busy == 1'b0, "R10 busy at done", busy, 0);
        done_seen = 1;
        chk_busy  = 0;
      end
    end
  end

  task automatic set_win(int l, int a, int b, int c, int d);
    lo1[l] = a; hi1[l] = b; lo2[l] = c; hi2[l] = d;
  endtask

  task automatic run_cal(int d0, int d1, bit mid_start, bit dflt_change,
                         string tag0, string tag1);
    int r0, r1, cyc;
    r0 = ref_result(0, d0);
    r1 = ref_result(1, d1);
    q_kind.push_back(0); q_dly.push_back('0); q_tag.push_back("R3 begin");
    for (int c = 0; c <= MAXC; c++) begin
      q_kind.push_back(1); q_dly.push_back({8'(d1), 8'(c)}); q_tag.push_back("R4 lane0 step");
    end
    for (int c = 0; c <= MAXC; c++) begin
      q_kind.push_back(1); q_dly.push_back({8'(c), 8'hFF}); q_tag.push_back("R4 lane1 step");
    end
    q_kind.push_back(1); q_dly.push_back({8'(r1), 8'(r0)}); q_tag.push_back("R10 final load");
    q_kind.push_back(2); q_dly.push_back('0); q_tag.push_back("R10 exit");

    @(negedge clk);
    dflt_dly  = {8'(d1), 8'(d0)};
    cal_start = 1'b1;
    @(negedge clk);
    cal_start = 1'b0;
    done_seen = 0;
    chk_busy  = 1;
    chk(busy == 1'b1, "R2 start accepted", busy, 1);
    if (dflt_change) dflt_dly = ~dflt_dly;  // R9 defaults captured at start
    if (mid_start) begin
      repeat (500) @(negedge clk);
      cal_start = 1'b1;  // R2 ignored while busy
      @(negedge clk);
      cal_start = 1'b0;
    end
    cyc = 0;
    while (!done_seen && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done_seen) begin
      chk(1'b0, "watchdog run", cyc, 20000);
      q_kind.delete(); q_dly.delete(); q_tag.delete();
      chk_busy = 0;
    end
    chk(lane_dly[7:0] == 8'(r0), tag0, lane_dly[7:0], r0);
    chk(lane_dly[15:8] == 8'(r1), tag1, lane_dly[15:8], r1);
    chk(phy_dly == {8'(r1), 8'(r0)}, "R10 phy final", phy_dly, {8'(r1), 8'(r0)});
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done one cycle", done_o, 0);
    chk(busy == 1'b0, "R10 idle after done", busy, 0);
    repeat (3) @(negedge clk);
    chk(lane_dly == {8'(r1), 8'(r0)}, "R10 results held", lane_dly, {8'(r1), 8'(r0)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog global", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int l = 0; l < 2; l++) set_win(l, 1, 0, 1, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(mode == 2'b00, "R1 mode", mode, 0);
    chk({lvl_start, lvl_load, lvl_exit} == 3'b000, "R1 pulses", {lvl_start, lvl_load, lvl_exit}, 0);
    chk(lane_dly == 16'h0, "R1 lane results", lane_dly, 0);
    chk(phy_dly == 16'h0, "R1 phy delays", phy_dly, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Two clean windows: 30 and 40 (R6 R7 R8)
    set_win(0, 40, 100, 1, 0);
    set_win(1, 120, 200, 1, 0);
    run_cal(8'h11, 8'h22, 0, 0, "R8 lane0 normal", "R8 lane1 normal");

    // Empty lane falls back; glitch before window ignored (R5 R9 R6)
    set_win(0, 1, 0, 1, 0);
    set_win(1, 10, 11, 60, 90);
    run_cal(8'h33, 8'h34, 0, 1, "R9 lane0 no pass", "R6 lane1 glitch skipped");

    // Window to the top end: no falling edge; window from code 0: no rising edge
    set_win(0, 200, 255, 1, 0);
    set_win(1, 0, 30, 1, 0);
    run_cal(8'h44, 8'h55, 0, 0, "R7 lane0 no fall", "R6 lane1 no rise");

    // Minimum window at the low bound, window whose fall is beyond 251, mid-run start
    set_win(0, 4, 7, 1, 0);
    set_win(1, 248, 251, 1, 0);
    run_cal(8'h12, 8'h66, 1, 0, "R6 lane0 min window", "R7 lane1 fall out of range");

    // Two windows take the first; window starting at 3 has no clean rise
    set_win(0, 20, 30, 100, 200);
    set_win(1, 3, 9, 1, 0);
    run_cal(8'h70, 8'h77, 0, 0, "R7 lane0 first window", "R6 lane1 start at 3");

    // Odd width truncates
    set_win(0, 9, 15, 1, 0);
    set_win(1, 51, 54, 1, 0);
    run_cal(8'h01, 8'h02, 0, 0, "R8 lane0 odd truncation", "R8 lane1 min width");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule